// File: doc/BRIEF.md
# Segment Access Protection Checker

This block sits between address generation and the memory pipeline. It takes the cached attributes of one memory segment, an offset into that segment, an access length and an access kind, and decides whether the access is legal. It checks the present flag, whether the segment is a memory segment or a system segment, read, write and fetch rights for code and data segments, and the segment bound. The bound can be counted in bytes or in 4 KiB pages, and data segments can grow downward. When the access is legal, the block forms the linear address as base plus offset.

Each accepted request produces one registered result one cycle later. The result carries the linear address, a fault flag and a cause code. A valid/ready pair on each side lets a downstream stall hold the result in place. Loading descriptors, paging and privilege rules for segment-register loads happen elsewhere.

Top module: `seg_guard`

## Requirements
- R1: When `in_gran` is 1, the effective byte bound is `(in_limit << 12) | 0xFFF`. When it is 0, the bound is `in_limit` in bytes.
- R2: A request with `in_present` = 0 reports cause 1 (absent). This takes priority over every other cause.
- R3: A code segment (`in_exec` = 1) always faults on a write (kind 1) with cause 3. It faults on a read (kind 0) only when `in_rw` = 0, and it allows a fetch (kind 2).
- R4: A data segment (`in_exec` = 0) always allows a read. It allows a write only when `in_rw` = 1, and it faults on a fetch with cause 3.
- R5: For a segment that grows upward, the access faults with cause 2 when `offset + in_len_m1` is greater than the effective bound. This sum is formed at 33 bits, so a carry out of bit 31 is a fault.
- R6: A data segment with `in_dir` = 1 grows downward. It faults with cause 2 when the offset is at or below the effective bound, or when `offset + in_len_m1` is above 0xFFFF (`in_big` = 0) or above 0xFFFFFFFF (`in_big` = 1). On a code segment, `in_dir` does not change the bound check.
- R7: A request with `in_is_mem` = 0 faults with cause 4 (system segment) when no higher-priority cause applies.
- R8: When several causes apply, the lowest nonzero code is reported. The order is absent (1), then bound (2), then rights (3), then system (4).
- R9: With cause 0, `out_linear` = (base + offset) mod 2^32 and `out_fault` = 0. With any nonzero cause, `out_fault` = 1 and `out_linear` = 0.
- R10: A request is taken when `in_valid` and `in_ready` are both high, and its result appears at the output after the next clock edge. While `out_valid` = 1 and `out_ready` = 0, the result holds, `in_ready` is 0 and no new request is taken.
- R11: Kind code 3 is reserved. Any request with kind 3 faults with cause 3 when no higher-priority cause applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_base | input | 32 | Segment base address |
| in_limit | input | 20 | Raw segment bound |
| in_present | input | 1 | Segment present |
| in_is_mem | input | 1 | 1 = code/data segment, 0 = system segment |
| in_exec | input | 1 | 1 = code segment, 0 = data segment |
| in_dir | input | 1 | Data: grows downward; code: conforming (no bound effect) |
| in_rw | input | 1 | Code: readable; data: writable |
| in_gran | input | 1 | Bound counted in 4 KiB pages |
| in_big | input | 1 | 32-bit segment (upper bound 0xFFFFFFFF, else 0xFFFF) |
| in_offset | input | 32 | Effective offset |
| in_len_m1 | input | 2 | Access length in bytes minus one |
| in_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed this cycle |
| out_linear | output | 32 | Linear address, zero on fault |
| out_fault | output | 1 | Access faults |
| out_cause | output | 3 | 0 none, 1 absent, 2 bound, 3 rights, 4 system |

## Verification
The state of this block lives only in the single output register. A wrong priority choice or a wrong bound comparison therefore shows up as a wrong cause code in the cycle right after the request is taken. A corrupted hold path shows up as a result that changes, or that is lost, while `out_ready` is low. The vectors place offsets exactly on each side of the bound, of the 16-bit and 32-bit upper ends, and of the 33-bit carry. A comparison that is off by one byte or one bit therefore flips a cause code at once.

// File: rtl/seg_guard_pkg.sv
// Shared types for the segment access checker.
// Assumes: access kind and cause encodings are fixed by the block's requirements.
package seg_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // Lower code wins when several causes apply.
    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_BOUND  = 3'd2,
        CAUSE_RIGHTS = 3'd3,
        CAUSE_SYSTEM = 3'd4
    } fault_cause_e;

endpackage

// File: rtl/seg_bound_check.sv
// Bound check for one access: scales the raw bound by granularity and
// compares the access span against it.
// Handles both segment directions. A downward segment also gets an upper
// ceiling chosen by the size flag.
// Assumes: LIMIT_W + PAGE_SHIFT <= ADDR_W and SMALL_W <= ADDR_W.
module seg_bound_check #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int SMALL_W    = 16,
    parameter int LEN_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [LIMIT_W-1:0] limit,
    input  logic              gran,
    input  logic              big,
    input  logic              expand_down,
    input  logic [ADDR_W-1:0] offset,
    input  logic [LEN_W-1:0]  len_m1,
    output logic [ADDR_W-1:0] eff_bound,
    output logic              bound_fault
);
    localparam int EXT_W    = ADDR_W + 1;
    localparam int SCALED_W = LIMIT_W + PAGE_SHIFT;

    logic [EXT_W-1:0] span_end;
    logic [EXT_W-1:0] ceiling;
    logic [EXT_W-1:0] bound_ext;

    // Effective byte bound from the raw bound and the granularity flag.
    always_comb begin
        if (gran) eff_bound = ADDR_W'({limit, {PAGE_SHIFT{1'b1}}});
        else      eff_bound = ADDR_W'(limit);
    end

    // Last byte touched, one bit wider so a carry past the top is kept.
    always_comb begin
        span_end  = {1'b0, offset} + EXT_W'(len_m1);
        bound_ext = {1'b0, eff_bound};
        ceiling   = big ? {1'b0, {ADDR_W{1'b1}}} : EXT_W'({SMALL_W{1'b1}});
    end

    // Fault decision for the two segment directions.
    always_comb begin
        if (expand_down) bound_fault = (offset <= eff_bound) || (span_end > ceiling);
        else             bound_fault = (span_end > bound_ext);
    end

    // Page granularity always fills the low page bits.
    assert_page_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && gran) |-> (eff_bound[PAGE_SHIFT-1:0] == {PAGE_SHIFT{1'b1}}));

    // A passing downward access starts strictly above the bound.
    assert_down_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && expand_down && !bound_fault) |-> (offset > eff_bound));

    // A passing upward access starts at or below the bound.
    assert_up_within_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !expand_down && !bound_fault) |-> (offset <= eff_bound));

    // Keep the scaled width visible for elaboration checks of the parameters.
    initial begin
        if (SCALED_W > ADDR_W) $display("seg_bound_check: scaled bound wider than address");
    end
endmodule

// File: rtl/seg_rights_check.sv
// Rights check for one access: code vs data segment rules for read,
// write and fetch. The reserved kind always fails.
// Assumes: kind encoding from seg_guard_pkg.
module seg_rights_check
    import seg_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chk_en,
    input  acc_kind_e kind,
    input  logic      exec,
    input  logic      rw,
    output logic      rights_fault
);
    // Per-kind permission decision.
    always_comb begin
        unique case (kind)
            ACC_READ:  rights_fault = exec & ~rw;
            ACC_WRITE: rights_fault = exec | ~rw;
            ACC_FETCH: rights_fault = ~exec;
            default:   rights_fault = 1'b1;
        endcase
    end

    // Code segments never take a write.
    assert_code_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && exec && kind == ACC_WRITE) |-> rights_fault);

    // Data segments always allow a read.
    assert_data_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !exec && kind == ACC_READ) |-> !rights_fault);

    // Reserved kind never passes.
    assert_rsvd_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && kind == ACC_RSVD) |-> rights_fault);
endmodule

// File: rtl/seg_result_stage.sv
// Single registered result stage with valid/ready handshake.
// Takes a new result when empty or when the held one is consumed.
// Assumes: the cause code is final at the input; linear is already zeroed on fault.
module seg_result_stage
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] d_linear,
    input  fault_cause_e      d_cause,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_linear,
    output logic              out_fault,
    output fault_cause_e      out_cause
);
    logic take;

    // The stage can accept when empty or being drained this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    // Result register: load on take, drain on consume, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_linear <= '0;
            out_fault  <= 1'b0;
            out_cause  <= CAUSE_NONE;
        end else if (take) begin
            out_valid  <= 1'b1;
            out_linear <= d_linear;
            out_fault  <= (d_cause != CAUSE_NONE);
            out_cause  <= d_cause;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
        end
    end

    // A stalled result must not move.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_linear) && $stable(out_cause)));

    // Faulting results never expose an address.
    assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_linear == '0));
endmodule

// File: rtl/seg_guard.sv
// Segment access protection checker (top).
// Combines the bound and rights checks with the present and memory-type
// flags. It picks one cause by fixed priority, forms base + offset, and
// registers the result.
// Assumes: the descriptor fields are stable while in_valid is high.
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int SMALL_W    = 16,
    parameter int LEN_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [LIMIT_W-1:0] in_limit,
    input  logic               in_present,
    input  logic               in_is_mem,
    input  logic               in_exec,
    input  logic               in_dir,
    input  logic               in_rw,
    input  logic               in_gran,
    input  logic               in_big,
    input  logic [ADDR_W-1:0]  in_offset,
    input  logic [LEN_W-1:0]   in_len_m1,
    input  logic [1:0]         in_kind,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_linear,
    output logic               out_fault,
    output logic [2:0]         out_cause
);
    logic              expand_down;
    logic [ADDR_W-1:0] eff_bound;
    logic              bound_fault;
    logic              rights_fault;
    fault_cause_e      cause_d;
    fault_cause_e      cause_q;
    logic [ADDR_W-1:0] linear_d;
    logic              take;

    // Only data segments grow downward; on code the flag means conforming.
    always_comb expand_down = in_dir & ~in_exec;

    seg_bound_check #(
        .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .PAGE_SHIFT(PAGE_SHIFT),
        .SMALL_W(SMALL_W), .LEN_W(LEN_W)
    ) i_bound (
        .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
        .limit(in_limit), .gran(in_gran), .big(in_big),
        .expand_down(expand_down), .offset(in_offset), .len_m1(in_len_m1),
        .eff_bound(eff_bound), .bound_fault(bound_fault)
    );

    seg_rights_check i_rights (
        .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
        .kind(acc_kind_e'(in_kind)), .exec(in_exec), .rw(in_rw),
        .rights_fault(rights_fault)
    );

    // Fixed-priority cause selection and address forming.
    always_comb begin
        if (!in_present)       cause_d = CAUSE_ABSENT;
        else if (bound_fault)  cause_d = CAUSE_BOUND;
        else if (rights_fault) cause_d = CAUSE_RIGHTS;
        else if (!in_is_mem)   cause_d = CAUSE_SYSTEM;
        else                   cause_d = CAUSE_NONE;
        linear_d = (cause_d == CAUSE_NONE) ? (in_base + in_offset) : '0;
    end

    seg_result_stage #(.ADDR_W(ADDR_W)) i_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .d_linear(linear_d), .d_cause(cause_d),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_linear(out_linear), .out_fault(out_fault), .out_cause(cause_q)
    );

    always_comb out_cause = cause_q;
    always_comb take = in_valid && in_ready;

    // An absent segment is reported as absent, whatever else is wrong.
    assert_absent_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_present) |=> (out_cause == 3'd1));

    // A system segment passing bound and rights checks reports the system cause.
    assert_system_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_present && !in_is_mem && !bound_fault && !rights_fault) |=> (out_cause == 3'd4));

    // A bound failure on a present segment outranks rights and type.
    assert_bound_over_rights_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_present && bound_fault) |=> (out_cause == 3'd2));

    // Each taken request yields a valid result next cycle.
    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);
endmodule

// File: tb/test_seg_guard.sv
// Bench for seg_guard: a vector table walked by one loop, then directed
// reset and handshake tests.
module test_seg_guard;

    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic [6:0]  attr;   // present, is_mem, exec, dir, rw, gran, big
        logic [31:0] off;
        logic [1:0]  len;
        logic [1:0]  kind;
        logic [2:0]  cause;
        logic [31:0] lin;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{32'h00001000, 20'h00FFF, 7'b1100101, 32'h00000010, 2'd3, 2'd0, 3'd0, 32'h00001010}, // R4 read data
        '{32'h00001000, 20'h00FFF, 7'b1100101, 32'h00000FFC, 2'd3, 2'd1, 3'd0, 32'h00001FFC}, // R5 last byte on bound
        '{32'h00001000, 20'h00FFF, 7'b1100101, 32'h00000FFD, 2'd3, 2'd1, 3'd2, 32'h00000000}, // R5 one past
        '{32'h00010000, 20'h00001, 7'b1100111, 32'h00001FFF, 2'd0, 2'd0, 3'd0, 32'h00011FFF}, // R1 page top
        '{32'h00010000, 20'h00001, 7'b1100111, 32'h00002000, 2'd0, 2'd0, 3'd2, 32'h00000000}, // R1 past page
        '{32'h00000000, 20'hFFFFF, 7'b1100111, 32'hFFFFFFFE, 2'd3, 2'd0, 3'd2, 32'h00000000}, // R5 carry out
        '{32'hFFFFFFF0, 20'hFFFFF, 7'b1100111, 32'h00000020, 2'd0, 2'd0, 3'd0, 32'h00000010}, // R9 wrap sum
        '{32'h00001000, 20'h00FFF, 7'b1100001, 32'h00000000, 2'd0, 2'd1, 3'd3, 32'h00000000}, // R4 write read-only
        '{32'h00001000, 20'h00FFF, 7'b1100101, 32'h00000000, 2'd0, 2'd2, 3'd3, 32'h00000000}, // R4 fetch data
        '{32'h00001000, 20'h00FFF, 7'b1110001, 32'h00000000, 2'd0, 2'd0, 3'd3, 32'h00000000}, // R3 read exec-only
        '{32'h00001000, 20'h00FFF, 7'b1110001, 32'h00000020, 2'd3, 2'd2, 3'd0, 32'h00001020}, // R3 fetch code
        '{32'h00001000, 20'h00FFF, 7'b1110101, 32'h00000040, 2'd1, 2'd0, 3'd0, 32'h00001040}, // R3 read readable
        '{32'h00001000, 20'h00FFF, 7'b1110101, 32'h00000040, 2'd0, 2'd1, 3'd3, 32'h00000000}, // R3 write code
        '{32'h00001000, 20'h00FFF, 7'b0100101, 32'h00002000, 2'd0, 2'd0, 3'd1, 32'h00000000}, // R2 absent + bound
        '{32'h00001000, 20'h00FFF, 7'b1000101, 32'h00000010, 2'd0, 2'd0, 3'd4, 32'h00000000}, // R7 system
        '{32'h00001000, 20'h00FFF, 7'b1000101, 32'h00002000, 2'd0, 2'd0, 3'd2, 32'h00000000}, // R8 system + bound
        '{32'h00001000, 20'h00FFF, 7'b1000101, 32'h00000010, 2'd0, 2'd2, 3'd3, 32'h00000000}, // R8 system + rights
        '{32'h00000000, 20'h00FFF, 7'b1101101, 32'h00000FFF, 2'd0, 2'd0, 3'd2, 32'h00000000}, // R6 at bound
        '{32'h00000000, 20'h00FFF, 7'b1101101, 32'h00001000, 2'd0, 2'd1, 3'd0, 32'h00001000}, // R6 just above
        '{32'h00000000, 20'h00FFF, 7'b1101101, 32'hFFFFFFFD, 2'd3, 2'd0, 3'd2, 32'h00000000}, // R6 32-bit ceiling
        '{32'h00020000, 20'h000FF, 7'b1101100, 32'h0000FFFE, 2'd1, 2'd0, 3'd0, 32'h0002FFFE}, // R6 16-bit top
        '{32'h00020000, 20'h000FF, 7'b1101100, 32'h0000FFFF, 2'd1, 2'd0, 3'd2, 32'h00000000}, // R6 16-bit past
        '{32'h00020000, 20'h000FF, 7'b1101100, 32'h00000100, 2'd0, 2'd0, 3'd0, 32'h00020100}, // R6 16-bit low
        '{32'h00001000, 20'h00FFF, 7'b1111001, 32'h00000010, 2'd0, 2'd2, 3'd0, 32'h00001010}, // R6 conforming code
        '{32'h00001000, 20'h00FFF, 7'b1111001, 32'h00001000, 2'd0, 2'd2, 3'd2, 32'h00000000}, // R6 code grows up
        '{32'h00001000, 20'h00FFF, 7'b1100101, 32'h00000000, 2'd0, 2'd3, 3'd3, 32'h00000000}  // R11 reserved kind
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_base = '0;
    logic [19:0] in_limit = '0;
    logic        in_present = 1'b0, in_is_mem = 1'b0, in_exec = 1'b0, in_dir = 1'b0;
    logic        in_rw = 1'b0, in_gran = 1'b0, in_big = 1'b0;
    logic [31:0] in_offset = '0;
    logic [1:0]  in_len_m1 = '0;
    logic [1:0]  in_kind = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_linear;
    logic        out_fault;
    logic [2:0]  out_cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    seg_guard i_seg_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_base(in_base), .in_limit(in_limit), .in_present(in_present),
        .in_is_mem(in_is_mem), .in_exec(in_exec), .in_dir(in_dir), .in_rw(in_rw),
        .in_gran(in_gran), .in_big(in_big), .in_offset(in_offset),
        .in_len_m1(in_len_m1), .in_kind(in_kind), .out_valid(out_valid),
        .out_ready(out_ready), .out_linear(out_linear), .out_fault(out_fault),
        .out_cause(out_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_base    = v.base;
        in_limit   = v.limit;
        {in_present, in_is_mem, in_exec, in_dir, in_rw, in_gran, in_big} = v.attr;
        in_offset  = v.off;
        in_len_m1  = v.len;
        in_kind    = v.kind;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R9 reset out_fault", 32'(out_fault), 32'd0);
        check("R9 reset out_linear", out_linear, 32'd0);
        check("R8 reset out_cause", 32'(out_cause), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle in_ready", 32'(in_ready), 32'd1);

        // Vector table: one request per cycle, result checked after one edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0s vec%0d valid", "10", i), 32'(out_valid), 32'd1);
            check($sformatf("vec%0d cause (R1..R11 table)", i), 32'(out_cause), 32'(VECS[i].cause));
            check($sformatf("R9 vec%0d fault", i), 32'(out_fault), 32'(VECS[i].cause != 3'd0));
            check($sformatf("R9 vec%0d linear", i), out_linear, VECS[i].lin);
        end

        // R10 bubble: no request, result drains.
        @(negedge clk);
        check("R10 drained", 32'(out_valid), 32'd0);

        // R10 backpressure: first result held, second request waits.
        drive(VECS[0]);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        check("R10 held valid", 32'(out_valid), 32'd1);
        check("R10 in_ready low", 32'(in_ready), 32'd0);
        drive(VECS[13]);
        @(negedge clk);
        check("R10 hold linear", out_linear, 32'h00001010);
        check("R10 hold cause", 32'(out_cause), 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second valid", 32'(out_valid), 32'd1);
        check("R2 second cause", 32'(out_cause), 32'd1);
        @(negedge clk);
        check("R10 second drained", 32'(out_valid), 32'd0);

        // R10 mid-run reset clears the stage.
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R10 reset clears", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        done  = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule